// File: doc/BRIEF.md
# Nibble-Loaded Bank Selector with Scaled Interval Timer

This block holds the bank numbers that steer a cartridge-style memory map. It has two 8 KB program windows and eight 1 KB pattern windows. The CPU loads each program bank number with one byte write. Each pattern bank number is built from two 4-bit writes, one to each of two addresses. One address fills the low half of the number and the other fills the high half, and the half that is not written stays as it was.

The block also contains an 8-bit up-counting interval timer, which is loaded through the same two-nibble scheme. The timer is clocked by CPU cycle strobes. It can count every strobe, or it can count through a fractional prescaler that fires about once every 113.67 strobes. When the counter wraps it reloads from the latch and raises a pending flag, and that flag drives the interrupt line.

The write port is a plain control port with no back-pressure. A write is taken in every cycle where `wr_en` is high, and the address and data are only looked at in that cycle. Only address bits [15:12] and [3:2] take part in decoding.

Top module: `nib_bank_ctrl`

## Requirements
- R1: After reset, all ten bank numbers read zero and `irq` is low. The timer latch, counter, enable field, prescaler and pending flag are also zero.
- R2: A write with address bits [15:12] = 0x8 loads the whole data byte into `prg_bank0`. A write with those bits = 0xA loads `prg_bank1`. All other address bits are ignored. Writes to any other range, for example 0x9, leave both program banks unchanged.
- R3: For address bits [15:12] in 0xB..0xE, let k = bits[15:12] − 0xB. The pattern bank written is 2k + addr[3]. When addr[2] = 0 the low nibble is written, and when addr[2] = 1 the high nibble is written. Only data[3:0] is used, the other nibble of that bank is kept, and address bits [11:4] and [1:0] are ignored.
- R4: In range 0xF, addr[3:2] = 00 loads data[3:0] into the low nibble of the timer latch, and addr[3:2] = 01 loads it into the high nibble. Both writes clear the pending flag.
- R5: A write in range 0xF with addr[3:2] = 10 sets the enable field to data[1:0] and clears pending. If data[1] is 1, the same write also copies the latch into the counter and zeroes the prescaler.
- R6: A write in range 0xF with addr[3:2] = 11 sets both enable bits to the current value of enable bit 0 and clears pending. This lets counting resume after an acknowledge.
- R7: When `cycle_mode` = 1 and enable bit 1 is set, each `cpu_tick` clocks the counter once. A clock at 0xFF reloads the counter from the latch and sets pending. `irq` equals pending.
- R8: When `cycle_mode` = 0 and enable bit 1 is set, each `cpu_tick` adds 3 to the prescaler. If the sum reaches 341, the counter is clocked once and the prescaler keeps the sum minus 341. From a prescaler of 0, the first clock therefore comes on the 114th strobe, and the next one on the 114th strobe after that.
- R9: Neither the counter nor the prescaler moves while enable bit 1 is clear, in a cycle without `cpu_tick`, or in any cycle that carries a write to range 0xF.
- R10: While `wr_en` is low, the address and data inputs have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one write per high cycle |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| cpu_tick | input | 1 | One-cycle strobe per CPU cycle for the timer |
| cycle_mode | input | 1 | 1: count every strobe, 0: count through the prescaler |
| prg_bank0 | output | 8 | Bank number of program window 0 |
| prg_bank1 | output | 8 | Bank number of program window 1 |
| chr_banks | output | 64 | Eight pattern bank numbers, bank i at bits [8i+7:8i] |
| irq | output | 1 | Interrupt request, equal to the pending flag |

## Verification
The hardest state to reach from the ports is the prescaler remainder. It is only visible through the moment of a counter wrap, and that moment depends on the leftover value from the wrap before it. The stimulus loads the latch with 0xFF, so every prescaler fire produces an overflow. It then checks that `irq` is still low one strobe before the fire and high exactly on the 114th strobe, over two fires in a row. The acknowledge restore is reached the same way. The enable field is set to 01 so that the counter stays frozen, and then an acknowledge write alone has to bring counting back.

// File: rtl/nbk_pkg.sv
package nbk_pkg;
  localparam int DATA_W   = 8;
  localparam int NIB_W    = 4;
  localparam int NUM_CHR  = 8;
  localparam int CHR_IDX_W = $clog2(NUM_CHR);

  typedef enum logic [2:0] {
    TMR_NONE,
    TMR_LATCH_LO,
    TMR_LATCH_HI,
    TMR_ENABLE,
    TMR_ACK
  } tmr_op_e;
endpackage

// File: rtl/nbk_decode.sv
module nbk_decode
  import nbk_pkg::*;
(
  input  logic                wr_en,
  input  logic [3:0]          addr_rng,
  input  logic [1:0]          addr_sel,
  output logic                prg0_we,
  output logic                prg1_we,
  output logic [NUM_CHR-1:0]  chr_lo_we,
  output logic [NUM_CHR-1:0]  chr_hi_we,
  output tmr_op_e             tmr_op
);
  logic                 in_chr;
  logic [3:0]           rng_off;
  logic [CHR_IDX_W-1:0] chr_idx;

  assign in_chr  = (addr_rng >= 4'hB) && (addr_rng <= 4'hE);
  assign rng_off = addr_rng - 4'hB;
  assign chr_idx = {rng_off[1:0], addr_sel[1]};

  always_comb begin
    prg0_we   = wr_en && (addr_rng == 4'h8);
    prg1_we   = wr_en && (addr_rng == 4'hA);
    chr_lo_we = '0;
    chr_hi_we = '0;
    if (wr_en && in_chr) begin
      if (addr_sel[0]) chr_hi_we[chr_idx] = 1'b1;
      else             chr_lo_we[chr_idx] = 1'b1;
    end
    tmr_op = TMR_NONE;
    if (wr_en && (addr_rng == 4'hF)) begin
      case (addr_sel)
        2'b00:   tmr_op = TMR_LATCH_LO;
        2'b01:   tmr_op = TMR_LATCH_HI;
        2'b10:   tmr_op = TMR_ENABLE;
        default: tmr_op = TMR_ACK;
      endcase
    end
  end
endmodule

// File: rtl/nbk_chr_regs.sv
module nbk_chr_regs
  import nbk_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CHR-1:0]         lo_we,
  input  logic [NUM_CHR-1:0]         hi_we,
  input  logic [NIB_W-1:0]           nib,
  output logic [NUM_CHR*DATA_W-1:0]  banks
);
  for (genvar i = 0; i < NUM_CHR; i++) begin : g_bank
    logic [NIB_W-1:0] lo_q, hi_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end else begin
        if (lo_we[i]) lo_q <= nib;
        if (hi_we[i]) hi_q <= nib;
      end
    end

    assign banks[i*DATA_W +: DATA_W] = {hi_q, lo_q};

    AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
      lo_we[i] |=> $stable(banks[i*DATA_W+NIB_W +: NIB_W])); // R3
    AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      hi_we[i] |=> $stable(banks[i*DATA_W +: NIB_W])); // R3
  end
endmodule

// File: rtl/nbk_timer.sv
module nbk_timer
  import nbk_pkg::*;
#(
  parameter int PRESCALE_STEP = 3,
  parameter int PRESCALE_WRAP = 341
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_op_e           op,
  input  logic [NIB_W-1:0]  nib,
  input  logic              tick,
  input  logic              cycle_mode,
  output logic              pending
);
  localparam int PW    = $clog2(PRESCALE_WRAP);
  localparam int SUM_W = PW + 1;

  logic [DATA_W-1:0] latch_q, cnt_q;
  logic [1:0]        en_q;
  logic [PW-1:0]     presc_q;
  logic [SUM_W-1:0]  step_sum;
  logic              wrap_hit, run, cnt_clk;

  assign step_sum = {1'b0, presc_q} + SUM_W'(PRESCALE_STEP);
  assign wrap_hit = step_sum >= SUM_W'(PRESCALE_WRAP);
  assign run      = en_q[1] && tick && (op == TMR_NONE);
  assign cnt_clk  = run && (cycle_mode || wrap_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      cnt_q   <= '0;
      en_q    <= '0;
      presc_q <= '0;
      pending <= 1'b0;
    end else begin
      case (op)
        TMR_LATCH_LO: begin
          latch_q[NIB_W-1:0] <= nib;
          pending <= 1'b0;
        end
        TMR_LATCH_HI: begin
          latch_q[DATA_W-1:NIB_W] <= nib;
          pending <= 1'b0;
        end
        TMR_ENABLE: begin
          en_q <= nib[1:0];
          if (nib[1]) begin
            cnt_q   <= latch_q;
            presc_q <= '0;
          end
          pending <= 1'b0;
        end
        TMR_ACK: begin
          en_q    <= {2{en_q[0]}};
          pending <= 1'b0;
        end
        default: begin
          if (run && !cycle_mode)
            presc_q <= wrap_hit ? PW'(step_sum - SUM_W'(PRESCALE_WRAP)) : step_sum[PW-1:0];
          if (cnt_clk) begin
            if (cnt_q == '1) begin
              cnt_q   <= latch_q;
              pending <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  AST_LATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == TMR_LATCH_LO || op == TMR_LATCH_HI) |=> !pending); // R4
  AST_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == TMR_ENABLE) |=> !pending); // R5
  AST_ACK_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == TMR_ACK) |=> (en_q == {2{$past(en_q[0])}}) && !pending); // R6
  AST_PEND_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> ($past(cnt_q) == '1)); // R7
  AST_PRESC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    presc_q < PW'(PRESCALE_WRAP)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q[1] && op == TMR_NONE) |=> ($stable(cnt_q) && $stable(presc_q))); // R9
endmodule

// File: rtl/nib_bank_ctrl.sv
module nib_bank_ctrl
  import nbk_pkg::*;
#(
  parameter int PRESCALE_STEP = 3,
  parameter int PRESCALE_WRAP = 341
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [15:0]                wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       cpu_tick,
  input  logic                       cycle_mode,
  output logic [DATA_W-1:0]          prg_bank0,
  output logic [DATA_W-1:0]          prg_bank1,
  output logic [NUM_CHR*DATA_W-1:0]  chr_banks,
  output logic                       irq
);
  logic                prg0_we, prg1_we;
  logic [NUM_CHR-1:0]  chr_lo_we, chr_hi_we;
  tmr_op_e             tmr_op;
  logic                unused_addr_bits;

  assign unused_addr_bits = ^{wr_addr[11:4], wr_addr[1:0]};

  nbk_decode u_decode (
    .wr_en     (wr_en),
    .addr_rng  (wr_addr[15:12]),
    .addr_sel  (wr_addr[3:2]),
    .prg0_we   (prg0_we),
    .prg1_we   (prg1_we),
    .chr_lo_we (chr_lo_we),
    .chr_hi_we (chr_hi_we),
    .tmr_op    (tmr_op)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prg_bank0 <= '0;
      prg_bank1 <= '0;
    end else begin
      if (prg0_we) prg_bank0 <= wr_data;
      if (prg1_we) prg_bank1 <= wr_data;
    end
  end

  nbk_chr_regs u_chr (
    .clk   (clk),
    .rst_n (rst_n),
    .lo_we (chr_lo_we),
    .hi_we (chr_hi_we),
    .nib   (wr_data[NIB_W-1:0]),
    .banks (chr_banks)
  );

  nbk_timer #(
    .PRESCALE_STEP (PRESCALE_STEP),
    .PRESCALE_WRAP (PRESCALE_WRAP)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .op         (tmr_op),
    .nib        (wr_data[NIB_W-1:0]),
    .tick       (cpu_tick),
    .cycle_mode (cycle_mode),
    .pending    (irq)
  );

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chr_lo_we, chr_hi_we, prg0_we, prg1_we, tmr_op != TMR_NONE})); // R3
  AST_IDLE_PRG: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(prg_bank0) && $stable(prg_bank1) && $stable(chr_banks))); // R10
endmodule

// File: tb/nib_bank_ctrl_tb.sv
module nib_bank_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        cpu_tick = 1'b0;
  logic        cycle_mode = 1'b1;
  logic [7:0]  prg_bank0, prg_bank1;
  logic [63:0] chr_banks;
  logic        irq;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  nib_bank_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cpu_tick(cpu_tick), .cycle_mode(cycle_mode),
    .prg_bank0(prg_bank0), .prg_bank1(prg_bank1),
    .chr_banks(chr_banks), .irq(irq)
  );

  // {addr, data, output select (0 prg0, 1 prg1, 2+i pattern bank i), expected}
  localparam int NV = 15;
  localparam logic [35:0] VEC [NV] = '{
    {16'h8000, 8'h12, 4'd0, 8'h12},  // R2
    {16'h8FFF, 8'h34, 4'd0, 8'h34},  // R2 extra address bits ignored
    {16'hA123, 8'h56, 4'd1, 8'h56},  // R2
    {16'hB000, 8'hA5, 4'd2, 8'h05},  // R3 low nibble, data[7:4] dropped
    {16'hB004, 8'h7C, 4'd2, 8'hC5},  // R3 high nibble keeps low
    {16'hB008, 8'h03, 4'd3, 8'h03},  // R3
    {16'hB00C, 8'hF9, 4'd3, 8'h93},  // R3
    {16'hC000, 8'h01, 4'd4, 8'h01},  // R3
    {16'hC00C, 8'h0E, 4'd5, 8'hE0},  // R3
    {16'hD004, 8'h02, 4'd6, 8'h20},  // R3
    {16'hD008, 8'h0B, 4'd7, 8'h0B},  // R3
    {16'hE000, 8'h06, 4'd8, 8'h06},  // R3
    {16'hE00C, 8'h0D, 4'd9, 8'hD0},  // R3
    {16'hE0F5, 8'h08, 4'd8, 8'h86},  // R3 bits outside decode ignored
    {16'h9000, 8'hFF, 4'd0, 8'h34}   // R2 undecoded range leaves prg0
  };

  function automatic logic [7:0] pick(input logic [3:0] sel);
    if (sel == 4'd0) return prg_bank0;
    if (sel == 4'd1) return prg_bank1;
    return chr_banks[(int'(sel) - 2) * 8 +: 8];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    cpu_tick = 1'b1;
    repeat (n) @(negedge clk);
    cpu_tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 prg0", prg_bank0, 8'h00);
    check("R1 chr7", chr_banks[63:56], 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][35:20], VEC[i][19:12]);
      check($sformatf("R2/R3 vector %0d", i), pick(VEC[i][11:8]), VEC[i][7:0]);
    end

    // R10: strobe low, address/data present
    @(negedge clk);
    wr_addr = 16'h8000; wr_data = 8'h99;
    @(negedge clk);
    check("R10 prg0 unchanged", prg_bank0, 8'h34);

    // R7 cycle mode, latch 0xFD
    cycle_mode = 1'b1;
    wr(16'hF000, 8'h0D);
    wr(16'hF004, 8'h0F);
    wr(16'hF008, 8'h02);               // R5 reload counter
    ticks(2);
    check("R7 no irq before wrap", {7'd0, irq}, 8'h00);
    ticks(1);
    check("R7 irq on wrap", {7'd0, irq}, 8'h01);
    wr(16'hF000, 8'h0D);
    check("R4 latch write clears pending", {7'd0, irq}, 8'h00);

    // R6 / R9: acknowledge with enable bit 0 clear stops counting
    wr(16'hF008, 8'h02);
    wr(16'hF00C, 8'h00);
    ticks(5);
    check("R6 ack with en0=0 stops", {7'd0, irq}, 8'h00);
    wr(16'hF008, 8'h01);               // R5 bit1 clear: no reload, no count
    ticks(5);
    check("R9 frozen with en1=0", {7'd0, irq}, 8'h00);
    wr(16'hF00C, 8'h00);               // R6 restore en1 from en0
    ticks(2);
    check("R6 resumed, not yet wrapped", {7'd0, irq}, 8'h00);
    ticks(1);
    check("R6 ack restored counting", {7'd0, irq}, 8'h01);

    // R8 prescaled mode, latch 0xFF
    cycle_mode = 1'b0;
    wr(16'hF000, 8'h0F);
    wr(16'hF008, 8'h02);
    ticks(113);
    check("R8 no fire at 113 strobes", {7'd0, irq}, 8'h00);
    ticks(1);
    check("R8 fire at 114th strobe", {7'd0, irq}, 8'h01);
    wr(16'hF004, 8'h0F);
    check("R4 high-nibble write clears pending", {7'd0, irq}, 8'h00);
    ticks(113);
    check("R8 remainder: none at 113", {7'd0, irq}, 8'h00);
    ticks(1);
    check("R8 remainder: fire at 114", {7'd0, irq}, 8'h01);

    // R1 reset again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 irq after reset", {7'd0, irq}, 8'h00);
    check("R1 prg1 after reset", prg_bank1, 8'h00);
    check("R1 chr0 after reset", chr_banks[7:0], 8'h00);

    finish_run();
  end
endmodule